// File: doc/BRIEF.md
# Ping-Pong Frame Capture Controller

This block steers where the pixels of a camera input land in memory. Software programs two buffer pairs, each made of a luma plane base and a chroma plane base, together with a line pitch. Once capture is enabled, every accepted pixel produces one write address for each plane. The address comes from the base of the active pair, the current line index times the pitch, and the pixel's byte offset within the line. Pixels are fixed at 2 bytes.

At every frame end the controller records how many lines the frame had and how long its final line was. It raises frame-end status and, in ping-pong mode, swaps to the other buffer pair so that software can drain one frame while the next is being written. Line-end and frame-end events set status bits. Software clears these bits by writing ones to them, and any status bit whose enable bit is set drives the interrupt line.

Disabling capture is deferred to the next frame boundary, so a frame in flight is always completed. If capture is disabled and then re-enabled inside the same frame, the next frame restarts on buffer pair 0. No other setting changes.

Top module: `frame_capture_pp`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `wr_valid_o` is 0.
- R2: The register word indices are: 0 control, 1 interrupt enable, 2 interrupt status, 3 pair-0 luma base, 4 pair-0 chroma base, 5 pair-1 luma base, 6 pair-1 chroma base, 7 line pitch, 8 last line count, 9 last pixel count. The control register has these fields:
  - bit 0: capture enable
  - bit 1: ping-pong mode
  - bit 2: line-loop mode
  - bits 15:12: burst length (0xF means 16 beats), stored and read back only

  Unimplemented control bits read 0. Written values read back combinationally.
- R3: `wr_valid_o` follows `pix_valid_i` only while capture is running. Capture starts in the second cycle after the write that sets enable. While capture is not running, events are ignored.
- R4: During a write cycle, `wr_addr_y_o` and `wr_addr_c_o` each equal the plane's base in the active pair, plus line index × pitch, plus 2 × pixel index in line. Indices count from 0 within the current frame and line.
- R5: The first frame after start uses pair 0. At each frame end, ping-pong mode swaps the active pair. Without ping-pong mode the pair stays the same, and it never changes mid-frame.
- R6: In line-loop mode the line term of the address is 0 for every line.
- R7: At a frame end, the last-line register (13 bits) captures the number of line ends in the frame. The last-pixel register (13 bits) captures the pixel count of the final line.
- R8: A frame end sets status bits 0 and 9, and a line end sets status bit 1. This applies only while running.
- R9: Writing 1 to a status bit clears it, so writing 0x3FF clears all ten bits. A set event in the same cycle as the clear wins over the clear.
- R10: `irq_o` is the OR of status ANDed with enable. It rises in the cycle after the event.
- R11: Clearing enable mid-frame lets the rest of that frame be written. After its frame end no writes occur.
- R12: Clearing and then re-setting enable within one frame makes the next frame use pair 0. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| pix_valid_i | input | 1 | One pixel accepted this cycle |
| line_end_i | input | 1 | Current pixel/cycle closes a line |
| frame_end_i | input | 1 | Current pixel/cycle closes a frame |
| wr_valid_o | output | 1 | Write address valid |
| wr_addr_y_o | output | 32 | Luma plane write address |
| wr_addr_c_o | output | 32 | Chroma plane write address |
| irq_o | output | 1 | Interrupt request |

## Verification
The write addresses and `wr_valid_o` are combinational on the pixel cycle itself. The bench therefore drives a pixel at the falling edge and checks the addresses 1 ns later, before the rising edge that counts the pixel. Status, the last-line and last-pixel counts, the active buffer pair and `irq_o` all change at the rising edge that takes the event. They are read at the following falling edge, because register reads are combinational. A write to enable takes two rising edges to start capture, one to store the bit and one to set the running state, and the bench waits an idle cycle after each start before it sends pixels.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RI_CTRL      = 4'd0,
    RI_IRQ_EN    = 4'd1,
    RI_IRQ_STAT  = 4'd2,
    RI_B0_Y      = 4'd3,
    RI_B0_C      = 4'd4,
    RI_B1_Y      = 4'd5,
    RI_B1_C      = 4'd6,
    RI_STRIDE    = 4'd7,
    RI_LAST_LINE = 4'd8,
    RI_LAST_PIX  = 4'd9
  } reg_idx_e;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_PP       = 1;
  localparam int CTRL_LL       = 2;
  localparam int BURST_LSB     = 12;
  localparam int BURST_W       = 4;
  localparam int ST_FRAME      = 0;
  localparam int ST_LINE       = 1;
  localparam int ST_POST_FRAME = 9;

  typedef struct packed {
    logic [BURST_W-1:0] burst;
    logic               line_loop;
    logic               ping_pong;
    logic               enable;
  } ctrl_t;
endpackage

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 13,
  parameter int IRQ_W = 10,
  parameter int NPL   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [REG_AW-1:0]        addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output ctrl_t                    ctrl_o,
  output logic [NPL-1:0][DW-1:0]   base0_o,
  output logic [NPL-1:0][DW-1:0]   base1_o,
  output logic [DW-1:0]            stride_o,
  input  logic                     ev_frame_i,
  input  logic                     ev_line_i,
  input  logic [CNT_W-1:0]         last_line_i,
  input  logic [CNT_W-1:0]         last_pix_i,
  output logic [IRQ_W-1:0]         stat_o,
  output logic [IRQ_W-1:0]         irq_en_o,
  output logic                     irq_o
);
  ctrl_t                   ctrl_q;
  logic [IRQ_W-1:0]        irq_en_q, stat_q, stat_set, stat_clr;
  logic [NPL-1:0][DW-1:0]  base0_q, base1_q;
  logic [DW-1:0]           stride_q;
  reg_idx_e                idx;

  assign idx = reg_idx_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      irq_en_q <= '0;
      base0_q  <= '0;
      base1_q  <= '0;
      stride_q <= '0;
    end else if (we_i) begin
      case (idx)
        RI_CTRL: begin
          ctrl_q.enable    <= wdata_i[CTRL_EN];
          ctrl_q.ping_pong <= wdata_i[CTRL_PP];
          ctrl_q.line_loop <= wdata_i[CTRL_LL];
          ctrl_q.burst     <= wdata_i[BURST_LSB +: BURST_W];
        end
        RI_IRQ_EN: irq_en_q   <= wdata_i[IRQ_W-1:0];
        RI_B0_Y:   base0_q[0] <= wdata_i;
        RI_B0_C:   base0_q[1] <= wdata_i;
        RI_B1_Y:   base1_q[0] <= wdata_i;
        RI_B1_C:   base1_q[1] <= wdata_i;
        RI_STRIDE: stride_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // status: set beats write-one-to-clear
  always_comb begin
    stat_set                = '0;
    stat_set[ST_FRAME]      = ev_frame_i;
    stat_set[ST_LINE]       = ev_line_i;
    stat_set[ST_POST_FRAME] = ev_frame_i;
    stat_clr = (we_i && idx == RI_IRQ_STAT) ? wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      RI_CTRL: begin
        rdata_o[CTRL_EN]                = ctrl_q.enable;
        rdata_o[CTRL_PP]                = ctrl_q.ping_pong;
        rdata_o[CTRL_LL]                = ctrl_q.line_loop;
        rdata_o[BURST_LSB +: BURST_W]   = ctrl_q.burst;
      end
      RI_IRQ_EN:    rdata_o[IRQ_W-1:0] = irq_en_q;
      RI_IRQ_STAT:  rdata_o[IRQ_W-1:0] = stat_q;
      RI_B0_Y:      rdata_o = base0_q[0];
      RI_B0_C:      rdata_o = base0_q[1];
      RI_B1_Y:      rdata_o = base1_q[0];
      RI_B1_C:      rdata_o = base1_q[1];
      RI_STRIDE:    rdata_o = stride_q;
      RI_LAST_LINE: rdata_o[CNT_W-1:0] = last_line_i;
      RI_LAST_PIX:  rdata_o[CNT_W-1:0] = last_pix_i;
      default: ;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign base0_o  = base0_q;
  assign base1_o  = base1_q;
  assign stride_o = stride_q;
  assign stat_o   = stat_q;
  assign irq_en_o = irq_en_q;
  assign irq_o    = |(stat_q & irq_en_q);
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pp_i,
  input  logic             pix_valid_i,
  input  logic             line_end_i,
  input  logic             frame_end_i,
  output logic             run_o,
  output logic             sel_o,
  output logic             stop_req_o,
  output logic             wr_valid_o,
  output logic             ev_frame_o,
  output logic             ev_line_o,
  output logic [CNT_W-1:0] line_cnt_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic [CNT_W-1:0] last_line_o,
  output logic [CNT_W-1:0] last_pix_o
);
  logic             run_q, sel_q, stop_req_q, stop_now, pix_inc;
  logic [CNT_W-1:0] line_cnt_q, pix_cnt_q, line_len_q, last_line_q, last_pix_q, pix_total;

  always_comb begin
    stop_now   = stop_req_q | ~en_i;
    ev_frame_o = run_q & frame_end_i;
    ev_line_o  = run_q & line_end_i;
    pix_inc    = run_q & pix_valid_i;
    pix_total  = pix_cnt_q + CNT_W'(pix_inc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      sel_q       <= 1'b0;
      stop_req_q  <= 1'b0;
      line_cnt_q  <= '0;
      pix_cnt_q   <= '0;
      line_len_q  <= '0;
      last_line_q <= '0;
      last_pix_q  <= '0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q      <= 1'b1;
        sel_q      <= 1'b0;
        stop_req_q <= 1'b0;
        line_cnt_q <= '0;
        pix_cnt_q  <= '0;
      end
    end else begin
      if (ev_frame_o) begin
        last_line_q <= line_cnt_q + CNT_W'(line_end_i);
        last_pix_q  <= line_end_i ? pix_total : line_len_q;
        line_cnt_q  <= '0;
        pix_cnt_q   <= '0;
        stop_req_q  <= 1'b0;
        run_q       <= en_i;
        if (stop_now)  sel_q <= 1'b0;
        else if (pp_i) sel_q <= ~sel_q;
      end else begin
        if (!en_i) stop_req_q <= 1'b1;
        if (ev_line_o) begin
          line_cnt_q <= line_cnt_q + 1'b1;
          pix_cnt_q  <= '0;
        end else if (pix_inc) begin
          pix_cnt_q  <= pix_total;
        end
      end
      if (ev_line_o) line_len_q <= pix_total;
    end
  end

  assign run_o       = run_q;
  assign sel_o       = sel_q;
  assign stop_req_o  = stop_req_q;
  assign wr_valid_o  = pix_inc;
  assign line_cnt_o  = line_cnt_q;
  assign pix_cnt_o   = pix_cnt_q;
  assign last_line_o = last_line_q;
  assign last_pix_o  = last_pix_q;
endmodule

// File: rtl/cap_addr.sv
module cap_addr #(
  parameter int DW        = 32,
  parameter int CNT_W     = 13,
  parameter int PIX_BYTES = 2,
  parameter int NPL       = 2
) (
  input  logic                   sel_i,
  input  logic                   line_loop_i,
  input  logic [CNT_W-1:0]       line_cnt_i,
  input  logic [CNT_W-1:0]       pix_cnt_i,
  input  logic [DW-1:0]          stride_i,
  input  logic [NPL-1:0][DW-1:0] base0_i,
  input  logic [NPL-1:0][DW-1:0] base1_i,
  output logic [NPL-1:0][DW-1:0] addr_o
);
  localparam logic [DW-1:0] PIX_STEP = DW'(PIX_BYTES);

  logic [DW-1:0] line_off, pix_off;

  assign line_off = line_loop_i ? '0 : DW'(line_cnt_i) * stride_i;
  assign pix_off  = DW'(pix_cnt_i) * PIX_STEP;

  for (genvar g = 0; g < NPL; g++) begin : g_plane
    logic [DW-1:0] base_sel;
    assign base_sel  = sel_i ? base1_i[g] : base0_i[g];
    assign addr_o[g] = base_sel + line_off + pix_off;
  end
endmodule

// File: rtl/frame_capture_pp.sv
module frame_capture_pp
  import cap_pkg::*;
#(
  parameter int DW        = 32,
  parameter int CNT_W     = 13,
  parameter int IRQ_W     = 10,
  parameter int PIX_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              pix_valid_i,
  input  logic              line_end_i,
  input  logic              frame_end_i,
  output logic              wr_valid_o,
  output logic [DW-1:0]     wr_addr_y_o,
  output logic [DW-1:0]     wr_addr_c_o,
  output logic              irq_o
);
  localparam int NPL = 2;

  ctrl_t                  ctrl_q;
  logic [NPL-1:0][DW-1:0] base0, base1, addr;
  logic [DW-1:0]          stride;
  logic [IRQ_W-1:0]       stat, irq_en;
  logic                   run_w, sel_w, stop_w, ev_frame, ev_line;
  logic [CNT_W-1:0]       line_cnt, pix_cnt, last_line, last_pix;

  cap_regs #(.DW(DW), .CNT_W(CNT_W), .IRQ_W(IRQ_W), .NPL(NPL)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl_q), .base0_o(base0), .base1_o(base1), .stride_o(stride),
    .ev_frame_i(ev_frame), .ev_line_i(ev_line),
    .last_line_i(last_line), .last_pix_i(last_pix),
    .stat_o(stat), .irq_en_o(irq_en), .irq_o(irq_o)
  );

  cap_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.enable), .pp_i(ctrl_q.ping_pong),
    .pix_valid_i, .line_end_i, .frame_end_i,
    .run_o(run_w), .sel_o(sel_w), .stop_req_o(stop_w), .wr_valid_o(wr_valid_o),
    .ev_frame_o(ev_frame), .ev_line_o(ev_line),
    .line_cnt_o(line_cnt), .pix_cnt_o(pix_cnt),
    .last_line_o(last_line), .last_pix_o(last_pix)
  );

  cap_addr #(.DW(DW), .CNT_W(CNT_W), .PIX_BYTES(PIX_BYTES), .NPL(NPL)) u_addr (
    .sel_i(sel_w), .line_loop_i(ctrl_q.line_loop),
    .line_cnt_i(line_cnt), .pix_cnt_i(pix_cnt), .stride_i(stride),
    .base0_i(base0), .base1_i(base1), .addr_o(addr)
  );

  assign wr_addr_y_o = addr[0];
  assign wr_addr_c_o = addr[1];
endmodule

// File: rtl/cap_chk.sv
module cap_chk #(
  parameter int DW    = 32,
  parameter int IRQ_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [3:0]       reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic             line_end_i,
  input logic             frame_end_i,
  input logic             wr_valid_o,
  input logic             irq_o,
  input logic             run,
  input logic             sel,
  input logic             stop_req,
  input logic             en,
  input logic             pp,
  input logic [IRQ_W-1:0] stat,
  input logic [IRQ_W-1:0] irq_en
);
  a_r3_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !wr_valid_o);

  a_r5_pp_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && run && pp && en && !stop_req |=> sel != $past(sel));

  a_r5_hold_mid_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !frame_end_i |=> $stable(sel));

  a_r12_start_pair0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> !sel);

  a_r9_w1c_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 4'd2 && reg_wdata_i[1] && !(line_end_i && run) |=> !stat[1]);

  a_r10_irq_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && run && irq_en[0] |=> irq_o);

  a_r11_stop_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && run && !en |=> !run);
endmodule

bind frame_capture_pp cap_chk #(.DW(DW), .IRQ_W(IRQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .line_end_i(line_end_i), .frame_end_i(frame_end_i),
  .wr_valid_o(wr_valid_o), .irq_o(irq_o),
  .run(run_w), .sel(sel_w), .stop_req(stop_w),
  .en(ctrl_q.enable), .pp(ctrl_q.ping_pong),
  .stat(stat), .irq_en(irq_en)
);

// File: tb/frame_capture_pp_test.sv
module frame_capture_pp_test;
  localparam logic [31:0] B0Y = 32'h1000_0000, B0C = 32'h2000_0000;
  localparam logic [31:0] B1Y = 32'h3000_0000, B1C = 32'h4000_0000;
  localparam logic [31:0] PITCH = 32'h0000_0100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, pv = 1'b0, le = 1'b0, fe = 1'b0;
  logic [3:0]  ra = '0;
  logic [31:0] wd = '0, rd, ay, ac;
  logic        wv, irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  frame_capture_pp uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .pix_valid_i(pv), .line_end_i(le), .frame_end_i(fe),
    .wr_valid_o(wv), .wr_addr_y_o(ay), .wr_addr_c_o(ac), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 0; pv = 0; le = 0; fe = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [31:0] exp, input string req);
    ra = a;
    #1;
    chk(rd, exp, req);
  endtask

  task automatic program_all();
    wr(4'd3, B0Y); wr(4'd4, B0C); wr(4'd5, B1Y); wr(4'd6, B1C); wr(4'd7, PITCH);
  endtask

  task automatic start(input logic [31:0] ctrl);
    wr(4'd0, ctrl);
    @(negedge clk);
  endtask

  // one pixel cycle; checks valid and (if expected) both plane addresses
  task automatic pix(input int line, input int p, input logic l_end, input logic f_end,
                     input logic exp_v, input logic psel, input logic loop, input string req);
    logic [31:0] off;
    pv = 1'b1; le = l_end; fe = f_end;
    #1;
    chk({31'd0, wv}, {31'd0, exp_v}, req);
    if (exp_v) begin
      off = (loop ? 32'd0 : line * PITCH) + p * 2;
      chk(ay, (psel ? B1Y : B0Y) + off, req);
      chk(ac, (psel ? B1C : B0C) + off, req);
    end
    @(negedge clk);
    pv = 1'b0; le = 1'b0; fe = 1'b0;
  endtask

  task automatic frame(input int lines, input int w, input logic psel, input logic loop, input string req);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < w; p++)
        pix(l, p, p == w - 1, (p == w - 1) && (l == lines - 1), 1'b1, psel, loop, req);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 10; i++) rchk(4'(i), 32'd0, "R1 reg zero");
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({31'd0, wv}, 32'd0, "R1 wr_valid");
    pix(0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 idle no write");
    rchk(4'd2, 32'd0, "R3 idle events ignored");
  endtask

  task automatic t_regs();
    do_reset();
    wr(4'd0, 32'hFFFF_FFF6);
    rchk(4'd0, 32'h0000_F006, "R2 ctrl fields");
    wr(4'd1, 32'hFFFF_FFFF);
    rchk(4'd1, 32'h0000_03FF, "R2 irq enable");
    program_all();
    rchk(4'd3, B0Y, "R2 b0y"); rchk(4'd6, B1C, "R2 b1c"); rchk(4'd7, PITCH, "R2 pitch");
  endtask

  task automatic t_pingpong();
    do_reset(); program_all();
    start(32'h0000_F003);
    frame(2, 3, 1'b0, 1'b0, "R4 R5 frame0 pair0");
    rchk(4'd8, 32'd2, "R7 last line");
    rchk(4'd9, 32'd3, "R7 last pixel");
    frame(3, 2, 1'b1, 1'b0, "R5 frame1 pair1");
    rchk(4'd8, 32'd3, "R7 last line f1");
    rchk(4'd9, 32'd2, "R7 last pixel f1");
    frame(1, 2, 1'b0, 1'b0, "R5 frame2 pair0");
  endtask

  task automatic t_single();
    do_reset(); program_all();
    start(32'h0000_0001);
    frame(2, 2, 1'b0, 1'b0, "R5 no pp f0");
    frame(2, 2, 1'b0, 1'b0, "R5 no pp f1 stays pair0");
  endtask

  task automatic t_lineloop();
    do_reset(); program_all();
    start(32'h0000_0005);
    frame(3, 2, 1'b0, 1'b1, "R6 line loop");
  endtask

  task automatic t_irq();
    do_reset(); program_all();
    wr(4'd1, 32'h0000_0001);
    start(32'h0000_0003);
    pix(0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 line");
    rchk(4'd2, 32'h0000_0002, "R8 line end sets bit1");
    chk({31'd0, irq}, 32'd0, "R10 line not enabled");
    pix(1, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 frame");
    rchk(4'd2, 32'h0000_0203, "R8 frame end sets bits 0 9");
    chk({31'd0, irq}, 32'd1, "R10 irq on frame end");
    wr(4'd2, 32'h0000_0001);
    rchk(4'd2, 32'h0000_0202, "R9 w1c bit0");
    chk({31'd0, irq}, 32'd0, "R10 irq drops");
    wr(4'd1, 32'h0000_0200);
    chk({31'd0, irq}, 32'd1, "R10 post frame enable");
    wr(4'd2, 32'h0000_03FF);
    rchk(4'd2, 32'd0, "R9 clear all");
    chk({31'd0, irq}, 32'd0, "R10 irq after clear");
    // set wins over clear in the same cycle
    we = 1'b1; ra = 4'd2; wd = 32'h0000_0002;
    pix(0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 collide");
    we = 1'b0;
    rchk(4'd2, 32'h0000_0002, "R9 set wins");
  endtask

  task automatic t_stop();
    do_reset(); program_all();
    start(32'h0000_0003);
    pix(0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 pre");
    pix(0, 1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 pre");
    wr(4'd0, 32'h0000_0002);
    pix(1, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 frame completes");
    pix(1, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11 frame completes");
    pix(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 no write after stop");
    pix(0, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 no write after stop");
    rchk(4'd8, 32'd2, "R11 stopped frame last line");
  endtask

  task automatic t_restart();
    do_reset(); program_all();
    start(32'h0000_0003);
    pix(0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R12 f0");
    wr(4'd0, 32'h0000_0002);
    wr(4'd0, 32'h0000_0003);
    pix(1, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R12 f0 continues");
    frame(1, 2, 1'b0, 1'b0, "R12 restart on pair0");
    rchk(4'd5, B1Y, "R12 base kept");
    rchk(4'd7, PITCH, "R12 pitch kept");
    rchk(4'd0, 32'h0000_0003, "R12 ctrl kept");
    frame(1, 2, 1'b1, 1'b0, "R12 then pair1");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_pingpong();
    t_single();
    t_lineloop();
    t_irq();
    t_stop();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule